// File: doc/BRIEF.md
# Programmable Up/Down Timer/Counter

This block is a 16-bit counter that steps up or down on each active edge of a selectable count clock. Three control inputs drive it: the count clock, a gate and a direction. Configuration bits choose whether each one comes from an external pin or from the block itself. For the count clock, the internal source is the system clock, so the counter steps on every cycle. For the gate and the direction, the internal sources are register bits. Each external input has its own polarity control. The terminal-count output also has a polarity control, and it pulses for one cycle each time the count wraps.

The external pins are asynchronous. Each passes through a two-stage synchronizer into the system clock domain. That clock must run at least four times faster than the external count clock. Software reaches the block through a plain byte-wide read/write port. Through this port it sets the configuration, loads a start value in two byte writes, and reads the count in two byte reads. The first read takes a snapshot of the whole count, so the two halves always belong together, and counting goes on undisturbed.

Top module: `updown_tmr`

## Requirements
- R1: After reset the count is 0x0000, configuration bytes at address 0 and address 1 read 0x00 (internal count clock, register gate closed, register direction down, every polarity active-high), and tc_o is low.
- R2: A write to address 2 stages the low byte. A write to address 3 loads {written byte, staged byte} into the count at that clock edge. A load takes priority over a count step in the same cycle.
- R3: With the internal count clock selected (address 0 bit 0 = 0) and the gate open, the count changes by one on every system clock. It counts up when the direction is up and down otherwise.
- R4: Counting wraps modulo 2^16 in both directions, and carries ripple across the byte boundary.
- R5: While the gate is closed, the count holds its value. With the register gate selected (address 0 bit 1 = 0), the gate is the register bit at address 0 bit 3.
- R6: With the external count clock selected (address 0 bit 0 = 1), each rising edge of ext_clk_i steps the count exactly once after synchronization. When address 0 bit 5 = 1, falling edges step it instead.
- R7: With the pin gate selected (address 0 bit 1 = 1), ext_gate_i opens the gate when high, whatever the value of the register gate bit. When address 0 bit 6 = 1, the gate opens when the pin is low.
- R8: With the pin direction selected (address 0 bit 2 = 1), ext_dir_i high means up. When address 0 bit 7 = 1, ext_dir_i low means up. With the register direction selected, address 0 bit 4 = 1 means up.
- R9: Each wrap (0xFFFF to 0x0000 up, or 0x0000 to 0xFFFF down) produces exactly one one-cycle pulse on tc_o. When address 1 bit 0 = 1, tc_o idles high and the pulse is low.
- R10: A read of address 2 returns the live low byte and captures the full count. A later read of address 3 returns the high byte of that captured value, even while counting continues. Neither read alters the count.
- R11: Reads of address 0 return the configuration byte as written. Reads of address 1 return the output-polarity bit in bit 0 and zeros above it. Read data appears on bus_rdata_o one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the external count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | Asynchronous external count clock pin |
| ext_gate_i | input | 1 | Asynchronous external gate pin |
| ext_dir_i | input | 1 | Asynchronous external direction pin |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| tc_o | output | 1 | Terminal-count pulse after polarity |

## Verification
A wrong count state shows up in the readback of the very next snapshot. A missed or doubled step, a reversed direction or a lost carry shifts the value by a known amount, because every run uses an exact cycle budget. A bad wrap decision shows up one cycle after the edge, as a missing or extra tc_o pulse. A fault in the synchronizer or edge detector shows up within three system cycles of a pin edge, as a count that differs from the number of pin pulses sent. A stale snapshot register shows up on the second byte read, which no longer matches the live value.

// File: rtl/tmr_pkg.sv
// Package: shared configuration type and register addresses for the
// up/down timer/counter. Assumes a byte-wide register port.
package tmr_pkg;

    // Configuration fields; the packed order gives the address 0 bit layout
    // (clk_ext is bit 0) and out_inv sits in address 1 bit 0.
    typedef struct packed {
        logic out_inv;   // terminal-count output active-low
        logic dir_inv;   // direction pin active-low
        logic gate_inv;  // gate pin active-low
        logic clk_inv;   // count clock pin counts on falling edges
        logic sw_up;     // register direction: 1 = up
        logic sw_gate;   // register gate: 1 = open
        logic dir_hw;    // direction from pin
        logic gate_hw;   // gate from pin
        logic clk_ext;   // count clock from pin
    } tmr_cfg_t;

    localparam logic [1:0] ADR_CFG_LO = 2'd0;
    localparam logic [1:0] ADR_CFG_HI = 2'd1;
    localparam logic [1:0] ADR_CNT_LO = 2'd2;
    localparam logic [1:0] ADR_CNT_HI = 2'd3;

endpackage

// File: rtl/tmr_sync.sv
// Module: tmr_sync
// Brings one asynchronous pin into the clk domain through STAGES flops
// and applies the polarity select, giving an active-high level.
// Assumes the pin stays stable for at least STAGES+1 clk cycles.
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic inv_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    // Polarity correction after synchronization.
    assign level_o = chain_q[STAGES-1] ^ inv_i;
endmodule

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Byte-wide register port: configuration, two-step load, and snapshot
// readback of the count. Assumes CNT_W == 2*BUS_W and BUS_W == 8.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] count_i,
    output tmr_cfg_t         cfg_o,
    output logic             load_en_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic [BUS_W-1:0] rdata_o
);
    localparam int HI_W = CNT_W - BUS_W;

    tmr_cfg_t         cfg_q;
    logic [BUS_W-1:0] stage_lo_q;
    logic [CNT_W-1:0] snap_q;

    // Configuration and staged low byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            stage_lo_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                ADR_CFG_LO: cfg_q[7:0]   <= wdata_i[7:0];
                ADR_CFG_HI: cfg_q.out_inv <= wdata_i[0];
                ADR_CNT_LO: stage_lo_q   <= wdata_i;
                default:    ;
            endcase
        end
    end

    // Load fires on the high-byte write.
    assign load_en_o  = wr_i && (addr_i == ADR_CNT_HI);
    assign load_val_o = {wdata_i[HI_W-1:0], stage_lo_q};

    // Registered read mux; a low-byte read also captures the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            snap_q  <= '0;
        end else if (rd_i) begin
            case (addr_i)
                ADR_CFG_LO: rdata_o <= cfg_q[7:0];
                ADR_CFG_HI: rdata_o <= BUS_W'(cfg_q.out_inv);
                ADR_CNT_LO: begin
                    rdata_o <= count_i[BUS_W-1:0];
                    snap_q  <= count_i;
                end
                default:    rdata_o <= BUS_W'(snap_q[CNT_W-1:BUS_W]);
            endcase
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/tmr_core.sv
// Module: tmr_core
// Counting engine: load, gated up/down step, modulo wrap and the
// registered terminal-count pulse with output polarity.
// Assumes tick_i is a one-cycle enable in the clk domain.
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             up_i,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             out_inv_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tc_raw_o,
    output logic             tc_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = '1;

    logic step;
    logic wrap;

    assign step = tick_i && gate_i && !load_en_i;
    assign wrap = up_i ? (count_o == MAX_CNT) : (count_o == '0);

    // Count register: load wins, otherwise step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n)         count_o <= '0;
        else if (load_en_i) count_o <= load_val_i;
        else if (step)      count_o <= up_i ? count_o + 1'b1 : count_o - 1'b1;
    end

    // Terminal-count pulse, aligned with the wrapped count.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_raw_o <= 1'b0;
        else        tc_raw_o <= step && wrap;
    end

    assign tc_o = tc_raw_o ^ out_inv_i;
endmodule

// File: rtl/updown_tmr.sv
// Module: updown_tmr
// Top of the programmable up/down timer/counter: synchronizes the three
// pins, selects sources, detects count-clock edges and ties the register
// port to the counting engine. Assumes clk >= 4x the external count clock.
module updown_tmr
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BUS_W     = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             ext_gate_i,
    input  logic             ext_dir_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o,
    output logic             tc_o
);
    localparam int N_PINS = 3;

    tmr_cfg_t         cfg;
    logic [N_PINS-1:0] pins, invs, levels;
    logic             clk_prev_q;
    logic             ext_rise;
    logic             tick, gate_on, up_on;
    logic             load_en;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_q;
    logic             tc_raw;

    assign pins = {ext_dir_i, ext_gate_i, ext_clk_i};
    assign invs = {cfg.dir_inv, cfg.gate_inv, cfg.clk_inv};

    // One synchronizer per external pin.
    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        tmr_sync #(.STAGES(SYNC_STG)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .inv_i  (invs[g]),
            .level_o(levels[g])
        );
    end

    // Remember the previous count-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev_q <= 1'b0;
        else        clk_prev_q <= levels[0];
    end

    assign ext_rise = levels[0] && !clk_prev_q;
    assign tick     = cfg.clk_ext ? ext_rise  : 1'b1;
    assign gate_on  = cfg.gate_hw ? levels[1] : cfg.sw_gate;
    assign up_on    = cfg.dir_hw  ? levels[2] : cfg.sw_up;

    tmr_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .count_i   (count_q),
        .cfg_o     (cfg),
        .load_en_o (load_en),
        .load_val_o(load_val),
        .rdata_o   (bus_rdata_o)
    );

    tmr_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .gate_i    (gate_on),
        .up_i      (up_on),
        .load_en_i (load_en),
        .load_val_i(load_val),
        .out_inv_i (cfg.out_inv),
        .count_o   (count_q),
        .tc_raw_o  (tc_raw),
        .tc_o      (tc_o)
    );
endmodule

// File: rtl/tmr_chk.sv
// Module: tmr_chk
// Property checker for updown_tmr, attached by the bind below.
module tmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ext_rise,
    input logic             gate_on,
    input logic             up_on,
    input logic             load_en,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count_q,
    input logic             tc_raw
);
    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count_q == $past(load_val));

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(tick && gate_on)) |=> $stable(count_q));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && tick && gate_on && up_on) |=> count_q == $past(count_q) + CNT_W'(1));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && tick && gate_on && !up_on) |=> count_q == $past(count_q) - CNT_W'(1));

    // R9
    tc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_raw |-> (count_q == '0 || count_q == '1));

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

bind updown_tmr tmr_chk #(.CNT_W(CNT_W)) i_tmr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ext_rise(ext_rise),
    .gate_on (gate_on),
    .up_on   (up_on),
    .load_en (load_en),
    .load_val(load_val),
    .count_q (count_q),
    .tc_raw  (tc_raw)
);

// File: tb/test_updown_tmr.sv
// Bench for updown_tmr: vector table of internal-clock runs, then
// directed tests for reset, pins, polarity, terminal count and snapshot.
module test_updown_tmr;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] init;
        logic [7:0]  waits;
        logic [15:0] expect_cnt;
    } vec_t;

    // Run length is waits+1 steps (enable and disable writes included).
    localparam vec_t VECS [6] = '{
        '{8'h18, 16'h0010, 8'd4, 16'h0015},  // R3 up
        '{8'h08, 16'h0010, 8'd4, 16'h000B},  // R3 down
        '{8'h18, 16'hFFFE, 8'd2, 16'h0001},  // R4 wrap up
        '{8'h08, 16'h0001, 8'd2, 16'hFFFE},  // R4 wrap down
        '{8'h10, 16'h1234, 8'd5, 16'h1234},  // R5 gate closed
        '{8'h18, 16'h00FF, 8'd0, 16'h0100}   // R4 byte carry
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0, ext_gate = 1'b0, ext_dir = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tc;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 0;
    logic tc_idle = 1'b0;
    int tc_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_tmr i_updown_tmr (
        .clk(clk), .rst_n(rst_n),
        .ext_clk_i(ext_clk), .ext_gate_i(ext_gate), .ext_dir_i(ext_dir),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tc_o(tc)
    );

    // Count cycles where tc_o leaves its idle level.
    always @(negedge clk) if (mon_on && tc !== tc_idle) tc_cnt++;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic load(input logic [15:0] v);
        wreg(2'd2, v[7:0]);
        wreg(2'd3, v[15:8]);
    endtask

    task automatic rcount(output logic [15:0] v);
        logic [7:0] lo, hi;
        rreg(2'd2, lo);
        rreg(2'd3, hi);
        v = {hi, lo};
    endtask

    task automatic pulse_clk(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tc_o", 16'(tc), 16'h0);
        rcount(v);            chk("R1 count", v, 16'h0000);
        rreg(2'd0, b);        chk("R1 cfg lo", 16'(b), 16'h00);
        rreg(2'd1, b);        chk("R1 cfg hi", 16'(b), 16'h00);

        // R11 configuration readback
        wreg(2'd0, 8'hA5);    rreg(2'd0, b); chk("R11 cfg lo", 16'(b), 16'hA5);
        wreg(2'd1, 8'hFF);    rreg(2'd1, b); chk("R11 cfg hi", 16'(b), 16'h01);
        wreg(2'd1, 8'h00);    wreg(2'd0, 8'h00);

        // Vector table: internal clock runs (R3, R4, R5, R2)
        foreach (VECS[i]) begin
            wreg(2'd0, VECS[i].cfg & 8'hF7);
            load(VECS[i].init);
            wreg(2'd0, VECS[i].cfg);
            repeat (VECS[i].waits) @(negedge clk);
            wreg(2'd0, VECS[i].cfg & 8'hF7);
            rcount(v);
            chk($sformatf("R3/R4/R5 vector %0d", i), v, VECS[i].expect_cnt);
        end

        // R2 load overrides counting: load while running, one step after
        wreg(2'd0, 8'h18);
        load(16'h1234);
        wreg(2'd0, 8'h10);
        rcount(v);            chk("R2 load while counting", v, 16'h1235);

        // R6 external clock, rising edges
        wreg(2'd0, 8'h01);
        repeat (4) @(negedge clk);
        load(16'h0300);
        wreg(2'd0, 8'h19);
        pulse_clk(2);
        repeat (4) @(negedge clk);
        wreg(2'd0, 8'h11);
        rcount(v);            chk("R6 rising edges", v, 16'h0302);

        // R6 external clock, falling edges with clk_inv
        wreg(2'd0, 8'h21);
        repeat (4) @(negedge clk);
        load(16'h0200);
        wreg(2'd0, 8'h39);
        pulse_clk(3);
        repeat (4) @(negedge clk);
        wreg(2'd0, 8'h31);
        rcount(v);            chk("R6 falling edges", v, 16'h0203);

        // R7 pin gate low holds count despite register gate bit
        ext_gate = 1'b0;
        wreg(2'd0, 8'h10);
        load(16'h0050);
        wreg(2'd0, 8'h1A);
        repeat (10) @(negedge clk);
        rcount(v);            chk("R7 pin gate closed", v, 16'h0050);
        // R7 gate_inv makes low pin open the gate
        wreg(2'd0, 8'h5A);
        repeat (4) @(negedge clk);
        wreg(2'd0, 8'h1A);
        rcount(v);            chk("R7 inverted pin gate", v, 16'h0055);

        // R8 pin direction low = down, inverted = up
        ext_dir = 1'b0;
        wreg(2'd0, 8'h04);
        repeat (4) @(negedge clk);
        load(16'h0064);
        wreg(2'd0, 8'h0C);
        repeat (3) @(negedge clk);
        wreg(2'd0, 8'h04);
        rcount(v);            chk("R8 pin dir down", v, 16'h0060);
        wreg(2'd0, 8'h84);
        load(16'h0064);
        wreg(2'd0, 8'h8C);
        repeat (3) @(negedge clk);
        wreg(2'd0, 8'h84);
        rcount(v);            chk("R8 inverted pin dir up", v, 16'h0068);

        // R9 terminal count, active-high, counting up through wrap
        wreg(2'd0, 8'h10);
        load(16'hFFFD);
        tc_cnt = 0; tc_idle = 1'b0; mon_on = 1;
        wreg(2'd0, 8'h18);
        repeat (6) @(negedge clk);
        wreg(2'd0, 8'h10);
        repeat (2) @(negedge clk);
        mon_on = 0;
        chk("R9 tc pulses up", 16'(tc_cnt), 16'd1);

        // R9 active-low output, counting down through wrap
        wreg(2'd1, 8'h01);
        chk("R9 tc idle high", 16'(tc), 16'h1);
        wreg(2'd0, 8'h00);
        load(16'h0002);
        tc_cnt = 0; tc_idle = 1'b1; mon_on = 1;
        wreg(2'd0, 8'h08);
        repeat (6) @(negedge clk);
        wreg(2'd0, 8'h00);
        repeat (2) @(negedge clk);
        mon_on = 0;
        chk("R9 tc pulses down inverted", 16'(tc_cnt), 16'd1);
        wreg(2'd1, 8'h00);

        // R10 snapshot consistency while counting
        wreg(2'd0, 8'h10);
        load(16'h00FF);
        wreg(2'd0, 8'h18);
        rreg(2'd2, b);        chk("R10 snapshot low", 16'(b), 16'h00FF);
        repeat (3) @(negedge clk);
        rreg(2'd3, b);        chk("R10 snapshot high", 16'(b), 16'h0000);
        wreg(2'd0, 8'h10);
        rcount(v);            chk("R10 counting undisturbed", v, 16'h0105);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule